// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip that follows the IEEE 1149.1 boundary-scan scheme. It has no dedicated test reset pin. The controller clears itself from a power-on reset input, or when the test mode select line is held high for five rising test-clock edges. The port state machine has the usual sixteen states. Behind it sit a three-bit instruction register, a one-bit bypass stage, a 32-bit identification register and a boundary register whose width is a parameter. The boundary register captures the levels of a vector of chip pins.

All inputs are sampled on the rising edge of the test clock. The serial output and its enable are retimed on the falling edge. The output is enabled only while a register is being shifted. The chip's real pad logic is reduced here to three outputs: the boundary update stage, a flag that hands the pads to that stage (external test), and a flag that forces all pads to high impedance (sample with pads floating). A chip integrator ties the pull-ups for undriven mode select and data lines at the pads. Inside this block both lines are plain logic inputs.

Top module: `scan_tap_ctrl`

## Requirements
- R1: While `por_n` is low at a rising `tck` edge, the controller goes to Test-Logic-Reset and the instruction becomes IDCODE. In the same condition, `tdo_oe`, `pin_drive_sel` and `pin_hiz` go low and `pin_drive` goes to 0 (`tdo_oe` at the falling edge).
- R2: From any of the sixteen states, five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset, and the instruction returns to IDCODE.
- R3: Capture-IR loads the pattern 3'b001 into the instruction shift stage. The stage shifts out bit 0 first, and `tdi` enters at bit 2.
- R4: Opcodes are 3'b000 external test, 3'b001 IDCODE, 3'b010 sample with pads floating, 3'b100 sample/preload and 3'b111 bypass. The unused codes 3'b011, 3'b101 and 3'b110 select bypass. The active instruction changes only on Update-IR or in Test-Logic-Reset.
- R5: Bypass is a single stage between `tdi` and `tdo`. It captures 0 in Capture-DR, so shifted data emerges one shift later.
- R6: Under IDCODE, Capture-DR loads the 32-bit parameter `ID_CODE`, whose bit 0 is 1. It shifts out bit 0 first.
- R7: External test, sample with pads floating, and sample/preload each select the boundary register. Capture-DR loads `pin_in[i]`, or 1 where `PH_MASK[i]` is set (placeholder cells). Bit 0 is nearest `tdo` and `tdi` enters at bit `BND_W-1`.
- R8: `pin_drive` takes the boundary shift stage on Update-DR only while the boundary register is selected, and holds otherwise. `pin_drive_sel` is high exactly under external test. `pin_hiz` is high exactly under sample with pads floating.
- R9: `tms` and `tdi` act on the rising `tck` edge. `tdo` and `tdo_oe` change only on the falling edge, so `tdo` does not move at a rising edge.
- R10: `tdo_oe` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, synchronous to `tck` |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| pin_in | input | BND_W | Pin levels sampled by the boundary register |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for `tdo` |
| pin_drive | output | BND_W | Boundary update stage, values for the pads |
| pin_drive_sel | output | 1 | Pads take `pin_drive` (external test) |
| pin_hiz | output | 1 | Pads forced to high impedance |

## Verification
The bench builds the block with a 6-bit boundary register, placeholder mask 6'b100001 and identification word 32'h5E3AC2D9. This makes all 64 pin patterns sweepable, each checked against its captured boundary image. All eight opcodes are loaded and scanned against an expected bit stream computed from the register length each opcode selects. Every one of the sixteen states is reached from Run-Test/Idle before the five-edge reset is applied, and shift timing is checked on both clock edges of every shifted bit.

// File: rtl/scan_tap_pkg.sv
// Shared definitions for the boundary-scan port: state encoding,
// instruction codes and the data-register selector.
// Assumes a 3-bit instruction register and a 32-bit identification word.
package scan_tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        TS_RESET     = 4'd0,
        TS_IDLE      = 4'd1,
        TS_SEL_DR    = 4'd2,
        TS_CAP_DR    = 4'd3,
        TS_SHIFT_DR  = 4'd4,
        TS_EXIT1_DR  = 4'd5,
        TS_PAUSE_DR  = 4'd6,
        TS_EXIT2_DR  = 4'd7,
        TS_UPD_DR    = 4'd8,
        TS_SEL_IR    = 4'd9,
        TS_CAP_IR    = 4'd10,
        TS_SHIFT_IR  = 4'd11,
        TS_EXIT1_IR  = 4'd12,
        TS_PAUSE_IR  = 4'd13,
        TS_EXIT2_IR  = 4'd14,
        TS_UPD_IR    = 4'd15
    } tap_state_t;

    typedef enum logic [1:0] {
        DR_BYPASS = 2'd0,
        DR_IDENT  = 2'd1,
        DR_BOUND  = 2'd2
    } dr_sel_t;

    localparam logic [IR_W-1:0] OP_EXTEST   = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;

    localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
// Sixteen-state port sequencer driven by tms on the rising tck edge.
// Assumes por_n is synchronous to tck; reset lands in Test-Logic-Reset.
module tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state selection from the current state and tms.
    always_comb begin
        nxt = state;
        unique case (state)
            TS_RESET:    nxt = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   nxt = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: nxt = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: nxt = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: nxt = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: nxt = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   nxt = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: nxt = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: nxt = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: nxt = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: nxt = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   nxt = tms ? TS_SEL_DR   : TS_IDLE;
            default:     nxt = TS_RESET;
        endcase
    end

    // State register with synchronous power-on reset.
    always_ff @(posedge tck) begin
        if (!por_n) state <= TS_RESET;
        else        state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction shift stage, active instruction and its decode.
// Assumes 3-bit opcodes; any code without a function selects bypass.
module tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  tap_state_t      state,
    output logic            ir_tdo,
    output logic [IR_W-1:0] instr,
    output dr_sel_t         dr_sel,
    output logic            drive_sel,
    output logic            hiz
);

    logic [IR_W-1:0] ir_sr;

    // Shift stage: fixed pattern on capture, serial shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!por_n)                  ir_sr <= IR_CAPTURE;
        else if (state == TS_CAP_IR) ir_sr <= IR_CAPTURE;
        else if (state == TS_SHIFT_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: IDCODE in reset, shift stage on update.
    always_ff @(posedge tck) begin
        if (!por_n || state == TS_RESET) instr <= OP_IDCODE;
        else if (state == TS_UPD_IR)     instr <= ir_sr;
    end

    assign ir_tdo = ir_sr[0];

    // Opcode decode into register select and pad control flags.
    always_comb begin
        dr_sel    = DR_BYPASS;
        drive_sel = 1'b0;
        hiz       = 1'b0;
        case (instr)
            OP_IDCODE:   dr_sel = DR_IDENT;
            OP_EXTEST:   begin dr_sel = DR_BOUND; drive_sel = 1'b1; end
            OP_SAMPLE_Z: begin dr_sel = DR_BOUND; hiz = 1'b1; end
            OP_SAMPLE:   dr_sel = DR_BOUND;
            default:     dr_sel = DR_BYPASS;
        endcase
    end

endmodule

// File: rtl/tap_dr.sv
// Data registers: bypass stage, identification register and the
// boundary register with its update stage.
// Assumes only the selected register captures and shifts.
module tap_dr
    import scan_tap_pkg::*;
#(
    parameter int               BND_W   = 16,
    parameter logic [BND_W-1:0] PH_MASK = '0,
    parameter logic [ID_W-1:0]  ID_CODE = 32'h0000_0001
)(
    input  logic             tck,
    input  logic             por_n,
    input  logic             tdi,
    input  tap_state_t       state,
    input  dr_sel_t          dr_sel,
    input  logic [BND_W-1:0] pin_in,
    output logic             dr_tdo,
    output logic [BND_W-1:0] bnd_upd
);

    localparam int LAST = BND_W - 1;

    logic             byp_q;
    logic [ID_W-1:0]  id_sr;
    logic [BND_W-1:0] bnd_sr;
    logic [BND_W-1:0] bnd_cap;
    logic [BND_W-1:0] bnd_sin;

    logic cap_en, sh_en;
    assign cap_en = (state == TS_CAP_DR);
    assign sh_en  = (state == TS_SHIFT_DR);

    // Bypass stage: zero on capture, follows tdi while shifting.
    always_ff @(posedge tck) begin
        if (!por_n)                                 byp_q <= 1'b0;
        else if (cap_en && dr_sel == DR_BYPASS)     byp_q <= 1'b0;
        else if (sh_en && dr_sel == DR_BYPASS)      byp_q <= tdi;
    end

    // Identification register: loads the fixed word, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!por_n)                                 id_sr <= ID_CODE;
        else if (cap_en && dr_sel == DR_IDENT)      id_sr <= ID_CODE;
        else if (sh_en && dr_sel == DR_IDENT)       id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Per-cell capture source and serial input of the boundary chain.
    for (genvar i = 0; i < BND_W; i++) begin : g_cell
        if (PH_MASK[i]) begin : g_ph
            assign bnd_cap[i] = 1'b1;
        end else begin : g_pin
            assign bnd_cap[i] = pin_in[i];
        end
        if (i == LAST) begin : g_head
            assign bnd_sin[i] = tdi;
        end else begin : g_link
            assign bnd_sin[i] = bnd_sr[i+1];
        end
    end

    // Boundary shift stage: pin capture, then serial shift.
    always_ff @(posedge tck) begin
        if (!por_n)                                 bnd_sr <= '0;
        else if (cap_en && dr_sel == DR_BOUND)      bnd_sr <= bnd_cap;
        else if (sh_en && dr_sel == DR_BOUND)       bnd_sr <= bnd_sin;
    end

    // Boundary update stage: takes the shift stage on Update-DR.
    always_ff @(posedge tck) begin
        if (!por_n)                                       bnd_upd <= '0;
        else if (state == TS_UPD_DR && dr_sel == DR_BOUND) bnd_upd <= bnd_sr;
    end

    // Serial output of the selected register.
    always_comb begin
        case (dr_sel)
            DR_IDENT: dr_tdo = id_sr[0];
            DR_BOUND: dr_tdo = bnd_sr[0];
            default:  dr_tdo = byp_q;
        endcase
    end

endmodule

// File: rtl/scan_tap_ctrl.sv
// Top of the boundary-scan port: sequencer, instruction path, data
// registers and falling-edge output retiming.
// Assumes por_n is held low for at least one tck cycle at power-up.
module scan_tap_ctrl
    import scan_tap_pkg::*;
#(
    parameter int               BND_W   = 16,
    parameter logic [BND_W-1:0] PH_MASK = 16'h8001,
    parameter logic [31:0]      ID_CODE = 32'h3C5A_1E97
)(
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic [BND_W-1:0] pin_in,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [BND_W-1:0] pin_drive,
    output logic             pin_drive_sel,
    output logic             pin_hiz
);

    tap_state_t      state;
    logic [IR_W-1:0] instr;
    dr_sel_t         dr_sel;
    logic            ir_tdo;
    logic            dr_tdo;

    tap_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    tap_ir u_ir (
        .tck       (tck),
        .por_n     (por_n),
        .tdi       (tdi),
        .state     (state),
        .ir_tdo    (ir_tdo),
        .instr     (instr),
        .dr_sel    (dr_sel),
        .drive_sel (pin_drive_sel),
        .hiz       (pin_hiz)
    );

    tap_dr #(
        .BND_W   (BND_W),
        .PH_MASK (PH_MASK),
        .ID_CODE (ID_CODE)
    ) u_dr (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .state   (state),
        .dr_sel  (dr_sel),
        .pin_in  (pin_in),
        .dr_tdo  (dr_tdo),
        .bnd_upd (pin_drive)
    );

    // Falling-edge retiming of the serial output and its enable.
    always_ff @(negedge tck) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == TS_SHIFT_IR) ? ir_tdo : dr_tdo;
            tdo_oe <= (state == TS_SHIFT_IR) || (state == TS_SHIFT_DR);
        end
    end

endmodule

// File: rtl/scan_tap_ctrl_chk.sv
// Property checker for the boundary-scan port, bound to the top.
// Assumes the top exposes its internal state and instruction signals.
module scan_tap_ctrl_chk
    import scan_tap_pkg::*;
#(
    parameter int BND_W = 16
)(
    input logic             tck,
    input logic             por_n,
    input logic             tms,
    input tap_state_t       state,
    input logic [IR_W-1:0]  instr,
    input logic             tdo_oe,
    input logic [BND_W-1:0] pin_drive,
    input logic             pin_drive_sel,
    input logic             pin_hiz
);

    logic [2:0] hi_cnt;

    // Count consecutive rising edges with tms high, saturating at five.
    always_ff @(posedge tck) begin
        if (!por_n)           hi_cnt <= 3'd0;
        else if (!tms)        hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
    end

    // R2
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!por_n)
        (hi_cnt == 3'd5) |-> (state == TS_RESET));

    // R1
    reset_idcode_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TS_RESET) |=> (instr == OP_IDCODE));

    // R4
    instr_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> (instr == $past(instr)));

    // R8
    drive_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state != TS_UPD_DR) |=> $stable(pin_drive));

    // R8
    pad_mode_excl_chk: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0({pin_drive_sel, pin_hiz}));

    // R10
    oe_shift_only_chk: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == TS_SHIFT_DR || state == TS_SHIFT_IR));

endmodule

bind scan_tap_ctrl scan_tap_ctrl_chk #(.BND_W(BND_W)) chk_i (
    .tck           (tck),
    .por_n         (por_n),
    .tms           (tms),
    .state         (state),
    .instr         (instr),
    .tdo_oe        (tdo_oe),
    .pin_drive     (pin_drive),
    .pin_drive_sel (pin_drive_sel),
    .pin_hiz       (pin_hiz)
);

// File: tb/scan_tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module scan_tap_ctrl_tb_top;

    localparam int          W   = 6;
    localparam logic [W-1:0] PH = 6'b100001;
    localparam logic [31:0] ID  = 32'h5E3A_C2D9;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b1;
    logic [W-1:0] pin_in = '0;
    logic tdo, tdo_oe, pin_drive_sel, pin_hiz;
    logic [W-1:0] pin_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 tck = ~tck;

    scan_tap_ctrl #(.BND_W(W), .PH_MASK(PH), .ID_CODE(ID)) dut_i (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pin_drive(pin_drive),
        .pin_drive_sel(pin_drive_sel), .pin_hiz(pin_hiz)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One tck cycle: inputs set after a falling edge, outputs read after the next one.
    task automatic step(input logic t, input logic d);
        tms = t; tdi = d;
        @(posedge tck);
        @(negedge tck);
        #0.5;
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        step(1, 1); step(1, 1); step(0, 1); step(0, 1);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            step(i == 2, op[i]);
        end
        step(1, 1); step(0, 1);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                           output bit t_ok, output bit oe_ok);
        dout = '0; t_ok = 1; oe_ok = 1;
        step(1, 1); step(0, 1); step(0, 1);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (tdo_oe !== 1'b1) oe_ok = 0;
            tms = (i == n - 1); tdi = din[i];
            @(posedge tck); #0.5;
            if (tdo !== dout[i]) t_ok = 0;
            @(negedge tck); #0.5;
        end
        if (tdo_oe !== 1'b0) oe_ok = 0;
        step(1, 1); step(0, 1);
    endtask

    function automatic logic [63:0] exp_scan(input logic [2:0] op, input logic [W-1:0] pins,
                                             input logic [63:0] din, input int n);
        logic [63:0] r; int len; logic [63:0] o;
        case (op)
            3'b001:                 begin r = {32'd0, ID}; len = 32; end
            3'b000, 3'b010, 3'b100: begin r = {58'd0, pins | PH}; len = W; end
            default:                begin r = 64'd0; len = 1; end
        endcase
        o = '0;
        for (int i = 0; i < n; i++) o[i] = (i < len) ? r[i] : din[i - len];
        return o;
    endfunction

    logic [2:0]  paths_len [16];
    logic [7:0]  paths_bits [16];

    initial begin
        logic [2:0] cap;
        logic [63:0] dout, din, ex;
        bit t_ok, oe_ok;

        paths_len[0]  = 3; paths_bits[0]  = 8'b111;
        paths_len[1]  = 0; paths_bits[1]  = 8'b0;
        paths_len[2]  = 1; paths_bits[2]  = 8'b1;
        paths_len[3]  = 2; paths_bits[3]  = 8'b01;
        paths_len[4]  = 3; paths_bits[4]  = 8'b001;
        paths_len[5]  = 3; paths_bits[5]  = 8'b101;
        paths_len[6]  = 4; paths_bits[6]  = 8'b0101;
        paths_len[7]  = 5; paths_bits[7]  = 8'b10101;
        paths_len[8]  = 4; paths_bits[8]  = 8'b1101;
        paths_len[9]  = 2; paths_bits[9]  = 8'b11;
        paths_len[10] = 3; paths_bits[10] = 8'b011;
        paths_len[11] = 4; paths_bits[11] = 8'b0011;
        paths_len[12] = 4; paths_bits[12] = 8'b1011;
        paths_len[13] = 5; paths_bits[13] = 8'b01011;
        paths_len[14] = 6; paths_bits[14] = 8'b101011;
        paths_len[15] = 5; paths_bits[15] = 8'b11011;

        // R1: power-on reset state
        repeat (3) @(negedge tck);
        #0.5;
        por_n = 1'b1;
        chk(tdo_oe === 1'b0, "R1 tdo_oe after reset", 64'(tdo_oe), 64'd0);
        chk(pin_drive === '0 && pin_drive_sel === 1'b0 && pin_hiz === 1'b0,
            "R1 pad outputs after reset", {pin_drive, pin_drive_sel, pin_hiz}, 64'd0);
        step(0, 1);
        din = 64'h0;
        scan_dr(32, din, dout, t_ok, oe_ok);
        chk(dout[31:0] === ID, "R6 identification word after reset", dout, 64'(ID));
        chk(dout[0] === 1'b1, "R6 identification bit 0", 64'(dout[0]), 64'd1);
        chk(t_ok, "R9 tdo still at rising edge", 64'(t_ok), 64'd1);
        chk(oe_ok, "R10 tdo_oe during and after shift", 64'(oe_ok), 64'd1);

        // R3 and R4/R5/R6/R7: every opcode against its expected scan stream
        for (int op = 0; op < 8; op++) begin
            load_ir(3'(op), cap);
            chk(cap === 3'b001, "R3 capture-IR pattern", 64'(cap), 64'd1);
            pin_in = 6'b010110;
            din = 64'h00A5_C396_F01E;
            scan_dr(40, din, dout, t_ok, oe_ok);
            ex = exp_scan(3'(op), pin_in, din, 40);
            chk(dout[39:0] === ex[39:0], "R4 opcode register length", dout, ex);
            chk(t_ok && oe_ok, "R9 R10 shift timing per opcode", {t_ok, oe_ok}, 64'd3);
        end

        // R7: all pin patterns captured with placeholder cells forced to 1
        load_ir(3'b100, cap);
        for (int p = 0; p < 64; p++) begin
            pin_in = 6'(p);
            scan_dr(W, 64'h15, dout, t_ok, oe_ok);
            chk(dout[W-1:0] === (6'(p) | PH), "R7 boundary capture", dout, 64'(6'(p) | PH));
        end

        // R8: preload, external test, floating pads, and holding under other registers
        scan_dr(W, 64'b101101, dout, t_ok, oe_ok);
        chk(pin_drive === 6'b101101 && !pin_drive_sel && !pin_hiz,
            "R8 preload under sample", {pin_drive, pin_drive_sel, pin_hiz}, {6'b101101, 2'b00});
        load_ir(3'b000, cap);
        chk(pin_drive === 6'b101101 && pin_drive_sel === 1'b1 && pin_hiz === 1'b0,
            "R8 external test flags", {pin_drive, pin_drive_sel, pin_hiz}, {6'b101101, 2'b10});
        scan_dr(W, 64'b010011, dout, t_ok, oe_ok);
        chk(pin_drive === 6'b010011, "R8 update under external test", 64'(pin_drive), 64'b010011);
        load_ir(3'b010, cap);
        chk(pin_hiz === 1'b1 && pin_drive_sel === 1'b0, "R8 floating pads flag",
            {pin_drive_sel, pin_hiz}, 64'b01);
        load_ir(3'b001, cap);
        scan_dr(32, 64'hFFFF_FFFF, dout, t_ok, oe_ok);
        chk(pin_drive === 6'b010011, "R8 drive held under IDCODE", 64'(pin_drive), 64'b010011);
        load_ir(3'b111, cap);
        scan_dr(8, 64'h3C, dout, t_ok, oe_ok);
        chk(pin_drive === 6'b010011 && !pin_drive_sel && !pin_hiz,
            "R5 R8 bypass leaves pads", {pin_drive, pin_drive_sel, pin_hiz}, {6'b010011, 2'b00});
        chk(dout[7:0] === 8'h78, "R5 one-stage bypass delay", dout, 64'h78);

        // R2: from each of the sixteen states, five tms-high edges reset the port
        for (int s = 0; s < 16; s++) begin
            load_ir(3'b111, cap);
            for (int k = 0; k < int'(paths_len[s]); k++) step(paths_bits[s][k], 1'b0);
            for (int k = 0; k < 5; k++) step(1, 1);
            chk(tdo_oe === 1'b0, "R2 tdo_oe in reset", 64'(tdo_oe), 64'd0);
            step(0, 1);
            scan_dr(32, 64'd0, dout, t_ok, oe_ok);
            chk(dout[31:0] === ID, "R2 IDCODE restored from state", 64'(s), 64'(ID));
        end

        // R1: power-on reset asserted mid-run restores IDCODE
        load_ir(3'b111, cap);
        por_n = 1'b0; tms = 1'b0;
        repeat (2) @(negedge tck);
        #0.5;
        chk(tdo_oe === 1'b0 && pin_drive === '0, "R1 reset mid-run",
            {pin_drive, tdo_oe}, 64'd0);
        por_n = 1'b1;
        step(0, 1);
        scan_dr(32, 64'd0, dout, t_ok, oe_ok);
        chk(dout[31:0] === ID, "R1 IDCODE after mid-run reset", dout, 64'(ID));

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule